// File: doc/BRIEF.md
# Video Test Pattern Generator

This block sits in the pixel path of a video encoder, between the timing generator and the output converters. When it is selected, it replaces the incoming YUV stream with an internally built test image. A 3-bit mode code chooses the image. The timing generator supplies the pixel column, the line number, an active-video flag and a one-cycle frame-start pulse. Software programs the active width and height, and the bar geometry is derived from them.

Several images are available:
- vertical or horizontal colour bars at 75% amplitude;
- a combination image with bars in the upper half and a luma ramp in the lower half;
- pseudo-random luma noise;
- a linear luma ramp;
- a constant mid-scale code on all three channels, which is used when sensing whether a converter is loaded.

Mode 0 passes the incoming video through unchanged. The mode is sampled only at frame start, so a picture never changes partway through a frame. Every output is registered and appears one clock after its inputs.

Top module: `vtpg_top`

## Requirements
- R1: While `rst` is high, the outputs hold the blanking level: Y = 16, U = V = 128. These and all codes below are 8-bit values, shifted left by DW-8 for wider samples. The latched mode while in reset is 0.
- R2: Each output sample is registered and reflects the inputs of the previous clock. In any mode, a cycle with `active` low produces the blanking level.
- R3: `mode_sel` is latched only in a cycle where `frame_start` is high. A change at any other time has no effect on the output until the next frame start.
- R4: Mode 0 (pass-through) copies `in_y`, `in_u` and `in_v` to the outputs.
- R5: Mode 2 (vertical bars) chooses bar index floor(8*pix_x / act_width). Indices 0 to 7 are, as Y/U/V: white 180/128/128, yellow 162/44/142, cyan 131/156/44, green 112/72/58, magenta 84/184/198, red 65/100/212, blue 35/212/114, black 16/128/128. A column at or beyond the width shows index 7.
- R6: Mode 3 (horizontal bars) uses the same colours, with the index floor(8*line_y / act_height).
- R7: Mode 1 (combination) shows the vertical bars of R5 on lines where 2*line_y < act_height, and the ramp of R9 on all other lines.
- R8: Mode 4 (noise) drives Y from bits 15..16-DW of a 16-bit register, and U = V = 128. The register is loaded with the seed 0xACE1 in a frame-start cycle. In every other cycle with `active` high, it shifts left with new bit 0 = b15^b13^b12^b10. In all other cycles it holds. The register is never zero.
- R9: Mode 5 (ramp) outputs Y = pix_x modulo 2^DW, with U = V = 128.
- R10: Mode 7 drives all three channels to the mid-scale code 128 during active video.
- R11: Mode 6 is unused and outputs the blanking level even during active video.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 3 | Requested pattern code |
| frame_start | input | 1 | One-cycle pulse at frame start, given in blanking |
| active | input | 1 | High during active video |
| pix_x | input | XW | Column within the active line |
| line_y | input | YW | Line within the active frame |
| act_width | input | XW | Programmed active width in pixels |
| act_height | input | YW | Programmed active height in lines |
| in_y | input | DW | Incoming luma |
| in_u | input | DW | Incoming blue-difference chroma |
| in_v | input | DW | Incoming red-difference chroma |
| out_y | output | DW | Output luma |
| out_u | output | DW | Output blue-difference chroma |
| out_v | output | DW | Output red-difference chroma |

## Verification
The bench targets the bar boundaries at widths that are and are not multiples of eight. At these points a design that divides by a truncated bar width, instead of scaling the position by eight, moves the edges or produces a ninth bar. It changes the mode in the middle of a frame, which would expose a design that decodes `mode_sel` directly. It also runs the noise source across a blanking gap and a new frame: a design that advances in blanking, or does not reseed, gives a different sequence. Finally, the ramp wrap, the mid-scale code, the unused code and blanking outside active video are each checked, so a swapped constant or a missing blank gate shows up at the outputs.

// File: rtl/vtpg_pkg.sv
package vtpg_pkg;

  typedef enum logic [2:0] {
    MD_PASS  = 3'd0,
    MD_COMBO = 3'd1,
    MD_VBAR  = 3'd2,
    MD_HBAR  = 3'd3,
    MD_NOISE = 3'd4,
    MD_RAMP  = 3'd5,
    MD_RSVD  = 3'd6,
    MD_MID   = 3'd7
  } mode_e;

  // 75% bar colours as 8-bit {Y, U, V}, index 0 at the left or top
  function automatic logic [23:0] bar_yuv8(input logic [2:0] idx);
    case (idx)
      3'd0:    return {8'd180, 8'd128, 8'd128};
      3'd1:    return {8'd162, 8'd44,  8'd142};
      3'd2:    return {8'd131, 8'd156, 8'd44};
      3'd3:    return {8'd112, 8'd72,  8'd58};
      3'd4:    return {8'd84,  8'd184, 8'd198};
      3'd5:    return {8'd65,  8'd100, 8'd212};
      3'd6:    return {8'd35,  8'd212, 8'd114};
      default: return {8'd16,  8'd128, 8'd128};
    endcase
  endfunction

endpackage

// File: rtl/vtpg_bar_index.sv
module vtpg_bar_index #(
  parameter int PW = 12
) (
  input  logic [PW-1:0] pos,
  input  logic [PW-1:0] span,
  output logic [2:0]    idx
);
  localparam int EW = PW + 3;

  logic [EW-1:0] pos8;
  logic [EW-1:0] span_e;
  logic [6:0]    ge;

  assign pos8   = {pos, 3'b000};
  assign span_e = EW'(span);

  // bar k starts where 8*pos reaches k*span
  for (genvar k = 1; k < 8; k++) begin : g_edge
    assign ge[k-1] = pos8 >= (EW'(k) * span_e);
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < 7; i++) idx = idx + {2'b00, ge[i]};
  end

endmodule

// File: rtl/vtpg_noise.sv
module vtpg_noise #(
  parameter int          DW   = 8,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          adv,
  output logic [DW-1:0] noise
);
  logic [15:0] lfsr;
  logic        fb;

  assign fb    = lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10];
  assign noise = lfsr[15 -: DW];

  always_ff @(posedge clk) begin
    if (rst || load) lfsr <= SEED;
    else if (adv)    lfsr <= {lfsr[14:0], fb};
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
    lfsr != 16'd0);  // R8
  AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(load) && !$past(adv)) |-> $stable(lfsr));  // R8

endmodule

// File: rtl/vtpg_top.sv
module vtpg_top
  import vtpg_pkg::*;
#(
  parameter int XW = 12,
  parameter int YW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    mode_sel,
  input  logic          frame_start,
  input  logic          active,
  input  logic [XW-1:0] pix_x,
  input  logic [YW-1:0] line_y,
  input  logic [XW-1:0] act_width,
  input  logic [YW-1:0] act_height,
  input  logic [DW-1:0] in_y,
  input  logic [DW-1:0] in_u,
  input  logic [DW-1:0] in_v,
  output logic [DW-1:0] out_y,
  output logic [DW-1:0] out_u,
  output logic [DW-1:0] out_v
);
  localparam int          SH      = DW - 8;
  localparam logic [DW-1:0] MID   = DW'(1) << (DW - 1);
  localparam logic [DW-1:0] BLK_Y = DW'(16) << SH;

  mode_e         mode_q;
  logic [2:0]    vidx, hidx;
  logic [23:0]   vcol, hcol;
  logic [DW-1:0] noise_y;
  logic          upper_half;
  logic [DW-1:0] nxt_y, nxt_u, nxt_v;

  vtpg_bar_index #(.PW(XW)) u_vidx (.pos(pix_x),  .span(act_width),  .idx(vidx));
  vtpg_bar_index #(.PW(YW)) u_hidx (.pos(line_y), .span(act_height), .idx(hidx));

  vtpg_noise #(.DW(DW)) u_noise (
    .clk(clk), .rst(rst), .load(frame_start), .adv(active), .noise(noise_y)
  );

  assign vcol       = bar_yuv8(vidx);
  assign hcol       = bar_yuv8(hidx);
  assign upper_half = {line_y, 1'b0} < {1'b0, act_height};

  always_ff @(posedge clk) begin
    if (rst)              mode_q <= MD_PASS;
    else if (frame_start) mode_q <= mode_e'(mode_sel);
  end

  always_comb begin
    nxt_y = BLK_Y;
    nxt_u = MID;
    nxt_v = MID;
    if (active) begin
      unique case (mode_q)
        MD_PASS: begin
          nxt_y = in_y; nxt_u = in_u; nxt_v = in_v;
        end
        MD_COMBO: begin
          if (upper_half) begin
            nxt_y = DW'(vcol[23:16]) << SH;
            nxt_u = DW'(vcol[15:8]) << SH;
            nxt_v = DW'(vcol[7:0]) << SH;
          end else begin
            nxt_y = DW'(pix_x);
          end
        end
        MD_VBAR: begin
          nxt_y = DW'(vcol[23:16]) << SH;
          nxt_u = DW'(vcol[15:8]) << SH;
          nxt_v = DW'(vcol[7:0]) << SH;
        end
        MD_HBAR: begin
          nxt_y = DW'(hcol[23:16]) << SH;
          nxt_u = DW'(hcol[15:8]) << SH;
          nxt_v = DW'(hcol[7:0]) << SH;
        end
        MD_NOISE: nxt_y = noise_y;
        MD_RAMP:  nxt_y = DW'(pix_x);
        MD_MID:   nxt_y = MID;
        default:  nxt_y = BLK_Y;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_y <= BLK_Y;
      out_u <= MID;
      out_v <= MID;
    end else begin
      out_y <= nxt_y;
      out_u <= nxt_u;
      out_v <= nxt_v;
    end
  end

  AST_BLANK_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
    !$past(active) |-> (out_y == BLK_Y && out_u == MID && out_v == MID));  // R2
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    !$past(frame_start) |-> $stable(mode_q));  // R3
  AST_MID_SCALE: assert property (@(posedge clk) disable iff (rst)
    ($past(active) && $past(mode_q) == MD_MID) |-> (out_y == MID && out_u == MID && out_v == MID));  // R10

endmodule

// File: tb/vtpg_top_tb.sv
module vtpg_top_tb;
  localparam int XW = 12;
  localparam int YW = 11;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] mode_sel = 3'd0;
  logic frame_start = 1'b0;
  logic active = 1'b0;
  logic [XW-1:0] pix_x = '0;
  logic [YW-1:0] line_y = '0;
  logic [XW-1:0] act_width = XW'(160);
  logic [YW-1:0] act_height = YW'(80);
  logic [DW-1:0] in_y = '0, in_u = '0, in_v = '0;
  logic [DW-1:0] out_y, out_u, out_v;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  vtpg_top #(.XW(XW), .YW(YW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .frame_start(frame_start),
    .active(active), .pix_x(pix_x), .line_y(line_y), .act_width(act_width),
    .act_height(act_height), .in_y(in_y), .in_u(in_u), .in_v(in_v),
    .out_y(out_y), .out_u(out_u), .out_v(out_v)
  );

  function automatic logic [23:0] ref_bar(input int idx);
    case (idx)
      0: return {8'd180, 8'd128, 8'd128};
      1: return {8'd162, 8'd44,  8'd142};
      2: return {8'd131, 8'd156, 8'd44};
      3: return {8'd112, 8'd72,  8'd58};
      4: return {8'd84,  8'd184, 8'd198};
      5: return {8'd65,  8'd100, 8'd212};
      6: return {8'd35,  8'd212, 8'd114};
      default: return {8'd16, 8'd128, 8'd128};
    endcase
  endfunction

  function automatic int ref_idx(input int pos, input int span);
    int q;
    q = (pos * 8) / span;
    return (q > 7) ? 7 : q;
  endfunction

  function automatic logic [15:0] ref_lfsr(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic chk(input string tag, input int ey, input int eu, input int ev);
    checks++;
    if (out_y !== DW'(ey) || out_u !== DW'(eu) || out_v !== DW'(ev)) begin
      fails++;
      $display("FAIL %s: got %0d/%0d/%0d expected %0d/%0d/%0d",
               tag, out_y, out_u, out_v, ey, eu, ev);
    end
  endtask

  task automatic step(input int x, input int y, input bit act, input bit fs);
    @(negedge clk);
    pix_x = XW'(x); line_y = YW'(y); active = act; frame_start = fs;
    @(posedge clk);
    #1;
  endtask

  task automatic new_frame(input int m);
    mode_sel = 3'(m);
    step(0, 0, 1'b0, 1'b1);
  endtask

  task automatic bar_check(input string tag, input int x, input int y, input int pos, input int span);
    logic [23:0] c;
    step(x, y, 1'b1, 1'b0);
    c = ref_bar(ref_idx(pos, span));
    chk(tag, c[23:16], c[15:8], c[7:0]);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    active = 1'b1; in_y = 8'd99;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset blank", 16, 128, 128);
    @(negedge clk); rst = 1'b0;
    step(3, 3, 1'b1, 1'b0);
    chk("R1 reset mode is pass-through", 99, 0, 0);
  endtask

  task automatic t_pass();
    in_y = 8'd201; in_u = 8'd7; in_v = 8'd250;
    step(10, 5, 1'b1, 1'b0);
    chk("R4 pass A", 201, 7, 250);
    in_y = 8'd0; in_u = 8'd255; in_v = 8'd128;
    step(11, 5, 1'b1, 1'b0);
    chk("R4 pass B", 0, 255, 128);
    step(12, 5, 1'b0, 1'b0);
    chk("R2 pass blanked outside active", 16, 128, 128);
  endtask

  task automatic t_mode_latch();
    in_y = 8'd77; in_u = 8'd66; in_v = 8'd55;
    mode_sel = 3'd2;
    step(0, 0, 1'b1, 1'b0);
    chk("R3 change ignored mid-frame", 77, 66, 55);
    new_frame(2);
    mode_sel = 3'd0;
    bar_check("R3 latched at frame start", 0, 0, 0, 160);
  endtask

  task automatic t_vbar();
    act_width = XW'(160);
    new_frame(2);
    bar_check("R5 col 0", 0, 4, 0, 160);
    bar_check("R5 col 19", 19, 4, 19, 160);
    bar_check("R5 col 20", 20, 4, 20, 160);
    bar_check("R5 col 100", 100, 4, 100, 160);
    bar_check("R5 col 159", 159, 4, 159, 160);
    bar_check("R5 beyond width", 170, 4, 170, 160);
    act_width = XW'(100);
    bar_check("R5 w100 col 12", 12, 4, 12, 100);
    bar_check("R5 w100 col 13", 13, 4, 13, 100);
    bar_check("R5 w100 col 87", 87, 4, 87, 100);
    bar_check("R5 w100 col 88", 88, 4, 88, 100);
    step(50, 4, 1'b0, 1'b0);
    chk("R2 bars blanked outside active", 16, 128, 128);
    act_width = XW'(160);
  endtask

  task automatic t_hbar();
    act_height = YW'(80);
    new_frame(3);
    bar_check("R6 line 0", 150, 0, 0, 80);
    bar_check("R6 line 9", 3, 9, 9, 80);
    bar_check("R6 line 10", 3, 10, 10, 80);
    bar_check("R6 line 79", 3, 79, 79, 80);
  endtask

  task automatic t_combo();
    new_frame(1);
    bar_check("R7 upper half bars", 45, 10, 45, 160);
    bar_check("R7 last bar line", 45, 39, 45, 160);
    step(45, 40, 1'b1, 1'b0);
    chk("R7 lower half ramp", 45, 128, 128);
  endtask

  task automatic t_noise();
    logic [15:0] s;
    new_frame(4);
    s = 16'hACE1;
    for (int i = 0; i < 6; i++) begin
      step(i, 0, 1'b1, 1'b0);
      chk("R8 noise sequence", s[15:8], 128, 128);
      s = ref_lfsr(s);
    end
    step(6, 0, 1'b0, 1'b0);
    chk("R8 noise blank gap", 16, 128, 128);
    step(0, 1, 1'b1, 1'b0);
    chk("R8 noise holds in blanking", s[15:8], 128, 128);
    new_frame(4);
    step(0, 0, 1'b1, 1'b0);
    chk("R8 reseed at frame start", 8'hAC, 128, 128);
  endtask

  task automatic t_ramp();
    new_frame(5);
    step(5, 2, 1'b1, 1'b0);
    chk("R9 ramp col 5", 5, 128, 128);
    step(255, 2, 1'b1, 1'b0);
    chk("R9 ramp col 255", 255, 128, 128);
    step(300, 2, 1'b1, 1'b0);
    chk("R9 ramp wraps", 44, 128, 128);
  endtask

  task automatic t_mid_rsvd();
    new_frame(7);
    step(33, 33, 1'b1, 1'b0);
    chk("R10 mid-scale", 128, 128, 128);
    step(33, 33, 1'b0, 1'b0);
    chk("R2 mid-scale blanked outside active", 16, 128, 128);
    new_frame(6);
    step(33, 33, 1'b1, 1'b0);
    chk("R11 unused code blank", 16, 128, 128);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_pass();
    t_mode_latch();
    t_vbar();
    t_hbar();
    t_combo();
    t_noise();
    t_ramp();
    t_mid_rsvd();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule